// File: doc/BRIEF.md
# Circular-Buffer Post-Modify Address Generator

This block produces one memory address per clock for indirect loads and stores. It holds four pointer registers, four signed step registers and four buffer-length registers. Each pointer also has a hidden start-of-buffer register, which is written together with the pointer. A register-load port writes any of these registers. When an access is requested, the block is told which pointer to use and which step register to add. It presents the pointer's current value as the address on the next cycle. In the same clock edge it advances that pointer by the chosen step, so the following access sees the new value.

When a pointer's length register is zero, the step is a plain 14-bit two's-complement add that wraps modulo 2^14. When the length L is nonzero, the pointer is kept inside the circular buffer [start, start+L). A stepped value at or past the end is pulled back by L, and one below the start is pushed forward by L. Steps must have a magnitude no greater than L. Two copies can run side by side because an access completes in a single cycle.

Top module: `modulo_agen`

## Requirements
- R1: After reset, every pointer, start, step and length register is zero, `addrValid` is 0 and `addrOut` is 0.
- R2: An access (`accEn`=1) at a clock edge makes `addrValid`=1 after that edge, with `addrOut` equal to the selected pointer's value before the step. A cycle without an access gives `addrValid`=0 and leaves `addrOut` unchanged.
- R3: The selected pointer advances by the selected step register, read as a signed 14-bit value, and the new value is seen by the next access to that pointer.
- R4: With length 0 the step is a modulo-2^14 add in both directions, so 16380+5 gives 1 and 2-4 gives 16382.
- R5: With length L≠0, a stepped value at or beyond start+L is reduced by L. A step equal to L returns the pointer to the same value.
- R6: With length L≠0, a stepped value below start is increased by L.
- R7: A write with `wrKind`=0 loads both the pointer and its start, 1 loads a step register, and 2 loads a length register. `wrIdx` selects the register. Code 3 changes nothing. An access in the same cycle as a step or length write uses the old value.
- R8: A pointer write in the same cycle as an access through that pointer wins over the step. The address emitted is still the old pointer value.
- R9: An access changes only the selected pointer; the other pointers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register-load strobe |
| wrKind | input | 2 | 0 pointer+start, 1 step, 2 length, 3 none |
| wrIdx | input | 2 | Register index for the load |
| wrData | input | 14 | Load value |
| accEn | input | 1 | Access request |
| accPtr | input | 2 | Pointer used by the access |
| accMod | input | 2 | Step register used by the access |
| addrOut | output | 14 | Pre-step address of the last access |
| addrValid | output | 1 | `addrOut` holds a fresh address |

## Verification
The hardest case to reach is a collision: a pointer load and an access through the same pointer in one cycle, followed at once by another access to that pointer. Only that second address shows whether the load or the step won. The stimulus builds it explicitly and also exercises negative steps that cross the buffer start. It checks a step equal to the buffer length and 14-bit rollover with a zero length. Back-to-back accesses through one pointer expose each step directly in the address stream.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int AGEN_AW   = 14;
  localparam int AGEN_REGS = 4;
  localparam int AGEN_SELW = $clog2(AGEN_REGS);

  typedef enum logic [1:0] {
    WK_PTR  = 2'd0,
    WK_MOD  = 2'd1,
    WK_LEN  = 2'd2,
    WK_NONE = 2'd3
  } wrKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 ptrWr;
    logic                 modWr;
    logic                 lenWr;
    logic [AGEN_SELW-1:0] wrIdx;
    logic                 issue;
    logic                 step;
    logic [AGEN_SELW-1:0] stepIdx;
    logic [AGEN_SELW-1:0] modIdx;
  } agenStrobe_t;
endpackage

// File: rtl/agen_ctrl.sv
module agen_ctrl
  import agen_pkg::*;
#(
  parameter int SELW = AGEN_SELW
) (
  input  logic            wrEn,
  input  logic [1:0]      wrKind,
  input  logic [SELW-1:0] wrIdx,
  input  logic            accEn,
  input  logic [SELW-1:0] accPtr,
  input  logic [SELW-1:0] accMod,
  output agenStrobe_t     strb
);
  logic ptrLoad;
  logic collide;

  assign ptrLoad = wrEn && (wrKind == WK_PTR);
  // a load of the pointer being stepped overrides the step
  assign collide = ptrLoad && (wrIdx == accPtr);

  always_comb begin
    strb         = '0;
    strb.ptrWr   = ptrLoad;
    strb.modWr   = wrEn && (wrKind == WK_MOD);
    strb.lenWr   = wrEn && (wrKind == WK_LEN);
    strb.wrIdx   = wrIdx;
    strb.issue   = accEn;
    strb.step    = accEn && !collide;
    strb.stepIdx = accPtr;
    strb.modIdx  = accMod;
  end
endmodule

// File: rtl/agen_modadd.sv
module agen_modadd #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stepVal,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);
  localparam int EW = AW + 2;

  logic [AW-1:0]        offset;
  logic signed [EW-1:0] offS;
  logic signed [EW-1:0] stepS;
  logic signed [EW-1:0] lenS;
  logic signed [EW-1:0] sum;
  logic signed [EW-1:0] folded;

  assign offset = ptr - base;
  assign offS   = signed'({2'b00, offset});
  assign stepS  = signed'({{2{stepVal[AW-1]}}, stepVal});
  assign lenS   = signed'({2'b00, len});
  assign sum    = offS + stepS;

  always_comb begin
    folded = sum;
    if (sum >= lenS)
      folded = sum - lenS;
    else if (sum < 0)
      folded = sum + lenS;
  end

  always_comb begin
    if (len == '0)
      nxt = ptr + stepVal;
    else
      nxt = base + folded[AW-1:0];
  end
endmodule

// File: rtl/agen_datapath.sv
module agen_datapath
  import agen_pkg::*;
#(
  parameter int AW   = AGEN_AW,
  parameter int NREG = AGEN_REGS,
  parameter int SELW = AGEN_SELW
) (
  input  logic          clk,
  input  logic          rstN,
  input  agenStrobe_t   strb,
  input  logic [AW-1:0] wrData,
  output logic [AW-1:0] addrOut,
  output logic          addrValid
);
  logic [AW-1:0] ptrR  [NREG];
  logic [AW-1:0] baseR [NREG];
  logic [AW-1:0] modR  [NREG];
  logic [AW-1:0] lenR  [NREG];

  logic [AW-1:0] selPtr;
  logic [AW-1:0] selBase;
  logic [AW-1:0] selLen;
  logic [AW-1:0] selMod;
  logic [AW-1:0] nxtPtr;

  assign selPtr  = ptrR[strb.stepIdx];
  assign selBase = baseR[strb.stepIdx];
  assign selLen  = lenR[strb.stepIdx];
  assign selMod  = modR[strb.modIdx];

  agen_modadd #(.AW(AW)) modadd_i (
    .ptr     (selPtr),
    .base    (selBase),
    .stepVal (selMod),
    .len     (selLen),
    .nxt     (nxtPtr)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hitWr;
    logic hitStep;
    assign hitWr   = (strb.wrIdx == SELW'(i));
    assign hitStep = strb.step && (strb.stepIdx == SELW'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptrR[i]  <= '0;
        baseR[i] <= '0;
      end else if (strb.ptrWr && hitWr) begin
        ptrR[i]  <= wrData;
        baseR[i] <= wrData;
      end else if (hitStep) begin
        ptrR[i]  <= nxtPtr;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        modR[i] <= '0;
        lenR[i] <= '0;
      end else begin
        if (strb.modWr && hitWr) modR[i] <= wrData;
        if (strb.lenWr && hitWr) lenR[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrOut   <= '0;
      addrValid <= 1'b0;
    end else begin
      addrValid <= strb.issue;
      if (strb.issue) addrOut <= selPtr;
    end
  end
endmodule

// File: rtl/modulo_agen.sv
module modulo_agen
  import agen_pkg::*;
#(
  parameter int AW   = AGEN_AW,
  parameter int NREG = AGEN_REGS,
  parameter int SELW = AGEN_SELW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [1:0]      wrKind,
  input  logic [SELW-1:0] wrIdx,
  input  logic [AW-1:0]   wrData,
  input  logic            accEn,
  input  logic [SELW-1:0] accPtr,
  input  logic [SELW-1:0] accMod,
  output logic [AW-1:0]   addrOut,
  output logic            addrValid
);
  agenStrobe_t strb;

  agen_ctrl #(.SELW(SELW)) ctrl_i (
    .wrEn   (wrEn),
    .wrKind (wrKind),
    .wrIdx  (wrIdx),
    .accEn  (accEn),
    .accPtr (accPtr),
    .accMod (accMod),
    .strb   (strb)
  );

  agen_datapath #(.AW(AW), .NREG(NREG), .SELW(SELW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .addrOut   (addrOut),
    .addrValid (addrValid)
  );
endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
  parameter int AW   = 14,
  parameter int NREG = 4,
  parameter int SELW = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [1:0]      wrKind,
  input logic [SELW-1:0] wrIdx,
  input logic [AW-1:0]   wrData,
  input logic            accEn,
  input logic [SELW-1:0] accPtr,
  input logic [SELW-1:0] accMod,
  input logic [AW-1:0]   addrOut,
  input logic            addrValid
);
  // shadows of written step and length values, taken from the load port
  logic [AW-1:0] modSh [NREG];
  logic [AW-1:0] lenSh [NREG];

  logic          r1Acc, r2Acc;
  logic [SELW-1:0] r1Ptr, r2Ptr;
  logic [AW-1:0] r2Mod, r1Mod;
  logic [AW-1:0] r2Len, r1Len;
  logic          r1Wr, r2Wr;
  logic [AW-1:0] r1WrData, r2WrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) begin
        modSh[i] <= '0;
        lenSh[i] <= '0;
      end
      r1Acc <= 1'b0; r2Acc <= 1'b0;
      r1Ptr <= '0;   r2Ptr <= '0;
      r1Mod <= '0;   r2Mod <= '0;
      r1Len <= '0;   r2Len <= '0;
      r1Wr  <= 1'b0; r2Wr  <= 1'b0;
      r1WrData <= '0; r2WrData <= '0;
    end else begin
      if (wrEn && wrKind == 2'd1) modSh[wrIdx] <= wrData;
      if (wrEn && wrKind == 2'd2) lenSh[wrIdx] <= wrData;
      r1Acc    <= accEn;
      r1Ptr    <= accPtr;
      r1Mod    <= modSh[accMod];
      r1Len    <= lenSh[accPtr];
      r1Wr     <= wrEn && wrKind == 2'd0 && wrIdx == accPtr;
      r1WrData <= wrData;
      r2Acc    <= r1Acc;
      r2Ptr    <= r1Ptr;
      r2Mod    <= r1Mod;
      r2Len    <= r1Len;
      r2Wr     <= r1Wr;
      r2WrData <= r1WrData;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!addrValid && addrOut == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    accEn |=> addrValid);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!accEn && $past(rstN)) |=> (!addrValid && $stable(addrOut)));

  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    (r1Acc && r2Acc && r1Ptr == r2Ptr && !r2Wr && r2Len == '0)
      |-> (addrOut == AW'($past(addrOut) + r2Mod)));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (r1Acc && r2Acc && r1Ptr == r2Ptr && r2Wr) |-> (addrOut == r2WrData));
endmodule

bind modulo_agen agen_checker #(.AW(AW), .NREG(NREG), .SELW(SELW)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKind(wrKind), .wrIdx(wrIdx),
  .wrData(wrData), .accEn(accEn), .accPtr(accPtr), .accMod(accMod),
  .addrOut(addrOut), .addrValid(addrValid)
);

// File: tb/modulo_agen_tb.sv
module modulo_agen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrKind = 2'd3;
  logic [1:0]  wrIdx = '0;
  logic [13:0] wrData = '0;
  logic        accEn = 1'b0;
  logic [1:0]  accPtr = '0;
  logic [1:0]  accMod = '0;
  logic [13:0] addrOut;
  logic        addrValid;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct { bit v; logic [13:0] a; string tag; } expItem_t;
  expItem_t expQ[$];

  // reference register state, built from the requirements
  logic [13:0] mP [4];
  logic [13:0] mB [4];
  logic [13:0] mM [4];
  logic [13:0] mL [4];

  always #2ns clk = ~clk;

  modulo_agen dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKind(wrKind), .wrIdx(wrIdx),
    .wrData(wrData), .accEn(accEn), .accPtr(accPtr), .accMod(accMod),
    .addrOut(addrOut), .addrValid(addrValid)
  );

  function automatic logic [13:0] stepRef(logic [13:0] p, logic [13:0] b,
                                          logic [13:0] m, logic [13:0] l);
    int off;
    logic [13:0] d;
    if (l == 14'd0) return p + m;
    d   = p - b;
    off = int'(d) + int'($signed(m));
    if (off >= int'(l)) off = off - int'(l);
    else if (off < 0)   off = off + int'(l);
    return 14'(int'(b) + off);
  endfunction

  task automatic cyc(bit we, logic [1:0] wk, logic [1:0] wi, logic [13:0] wd,
                     bit ae, logic [1:0] ap, logic [1:0] am, string tag);
    expItem_t e;
    logic [13:0] nx;
    @(negedge clk);
    wrEn = we; wrKind = wk; wrIdx = wi; wrData = wd;
    accEn = ae; accPtr = ap; accMod = am;
    e.v = ae; e.a = mP[ap]; e.tag = tag;
    expQ.push_back(e);
    nx = stepRef(mP[ap], mB[ap], mM[am], mL[ap]);
    if (ae) mP[ap] = nx;
    if (we) begin
      case (wk)
        2'd0: begin mP[wi] = wd; mB[wi] = wd; end
        2'd1: mM[wi] = wd;
        2'd2: mL[wi] = wd;
        default: ;
      endcase
    end
  endtask

  task automatic load(logic [1:0] k, logic [1:0] i, logic [13:0] d);
    cyc(1'b1, k, i, d, 1'b0, 2'd0, 2'd0, "R7 load");
  endtask

  task automatic acc(logic [1:0] p, logic [1:0] m, string tag);
    cyc(1'b0, 2'd3, 2'd0, 14'd0, 1'b1, p, m, tag);
  endtask

  task automatic idle(string tag);
    cyc(1'b0, 2'd3, 2'd0, 14'd0, 1'b0, 2'd0, 2'd0, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // monitor: compares each cycle's result one step after the edge
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #1ns;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (addrValid !== e.v || (e.v && addrOut !== e.a)) begin
          fails++;
          $display("FAIL %s: valid=%0b addr=%0d expected valid=%0b addr=%0d",
                   e.tag, addrValid, addrOut, e.v, e.a);
        end
      end
    end
  end

  initial begin
    #(4ns * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      mP[i] = '0; mB[i] = '0; mM[i] = '0; mL[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (addrValid !== 1'b0 || addrOut !== 14'd0) begin
      fails++;
      $display("FAIL R1: valid=%0b addr=%0d expected valid=0 addr=0", addrValid, addrOut);
    end
    // R1: registers zero, stepping by zero keeps pointer 0
    acc(2'd0, 2'd1, "R1 zero pointer");
    acc(2'd0, 2'd1, "R1 zero step");
    // R2 R3: forward steps
    load(2'd0, 2'd0, 14'd100);
    load(2'd1, 2'd0, 14'd3);
    acc(2'd0, 2'd0, "R2 pre-step address");
    acc(2'd0, 2'd0, "R3 step +3");
    acc(2'd0, 2'd0, "R3 step +3 again");
    idle("R2 idle no valid");
    // R4: rollover upward and downward
    load(2'd0, 2'd1, 14'd16380);
    load(2'd1, 2'd1, 14'd5);
    acc(2'd1, 2'd1, "R4 before rollover");
    acc(2'd1, 2'd1, "R4 after rollover");
    acc(2'd1, 2'd1, "R4 linear");
    load(2'd0, 2'd2, 14'd10);
    load(2'd1, 2'd2, 14'h3FFC);
    for (int k = 0; k < 5; k++) acc(2'd2, 2'd2, "R4 negative step wrap");
    // R5: circular buffer [200,210)
    load(2'd0, 2'd3, 14'd200);
    load(2'd2, 2'd3, 14'd10);
    for (int k = 0; k < 6; k++) acc(2'd3, 2'd0, "R5 upper wrap");
    // R6: negative step below start
    load(2'd0, 2'd3, 14'd201);
    for (int k = 0; k < 5; k++) acc(2'd3, 2'd2, "R6 lower wrap");
    // R5 boundary: step equal to length
    load(2'd1, 2'd3, 14'd10);
    acc(2'd3, 2'd3, "R5 step equals length");
    acc(2'd3, 2'd3, "R5 step equals length again");
    // R8: pointer load collides with access
    cyc(1'b1, 2'd0, 2'd0, 14'd500, 1'b1, 2'd0, 2'd0, "R8 old address emitted");
    acc(2'd0, 2'd0, "R8 load wins");
    acc(2'd0, 2'd0, "R8 step after load");
    // R7: code 3 ignored; same-cycle step write uses old step
    cyc(1'b1, 2'd3, 2'd0, 14'd999, 1'b0, 2'd0, 2'd0, "R7 code3 cycle");
    acc(2'd0, 2'd0, "R7 code3 no effect");
    cyc(1'b1, 2'd1, 2'd0, 14'd7, 1'b1, 2'd0, 2'd0, "R7 same-cycle step write");
    acc(2'd0, 2'd0, "R7 old step used");
    acc(2'd0, 2'd0, "R7 new step used");
    // R9: other pointers untouched
    acc(2'd1, 2'd0, "R9 access pointer 1");
    acc(2'd2, 2'd0, "R9 access pointer 2");
    acc(2'd0, 2'd1, "R9 pointer 0 unchanged");
    cyc(1'b0, 2'd3, 2'd0, 14'd0, 1'b1, 2'd3, 2'd1, "R9 pointer 3 unchanged");
    idle("R2 drain");
    idle("R2 drain");
    repeat (3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule